// File: doc/BRIEF.md
# Open-Row SDRAM Read Sequencer

This block sits between a simple host read port and a single SDRAM device with a 16-bit data bus. Each host request names a bank, a row and a column. The block converts the request into SDRAM commands and hands back two data words per request, because every SDRAM read is a fixed two-word burst. It keeps exactly one row open after a read. A later request to the same bank and row goes straight to a READ. A request to any other bank or row first closes the open row, then opens the new one, and only then reads.

The four SDRAM timing values are supplied on configuration inputs in whole clock cycles: read latency, activate-to-read delay, minimum row-active time and precharge time. They are expected to stay constant while requests are in flight. Requests use a valid/ready handshake, and only one request is held inside the block at a time. Returned words carry a one-cycle valid strobe each and appear in request order.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is asserted, the command pins show NOP and `rsp_valid` is low. After reset, `req_ready` is high.
- R2: `sd_cke` is high and every bit of `sd_dqm` is low in every cycle.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} use these encodings: NOP = 0111, ACTIVATE = 0011, READ = 0101, PRECHARGE = 0010. No other pattern is driven.
- R4: ACTIVATE carries the request bank on `sd_ba` and the row spread over {`sd_a_hi`, `sd_a10`, `sd_a_lo`} as row[12:11], row[10], row[9:0]. The first READ to that row comes exactly tRCD clocks after the ACTIVATE.
- R5: READ carries the request bank on `sd_ba` and the column on `sd_a_lo`, with `sd_a10` and `sd_a_hi` low, so the row stays open. PRECHARGE drives the open bank with `sd_a10` low.
- R6: A request whose bank and row match the open row issues READ with no ACTIVATE. With requests waiting, consecutive READs are exactly 2 clocks apart (READ, NOP, READ).
- R7: A request to a different row or bank issues PRECHARGE, then ACTIVATE of the new row exactly tRP clocks later, then READ tRCD clocks after that.
- R8: PRECHARGE comes no sooner than tRAS clocks after the ACTIVATE of the row it closes. When a miss is waiting on tRAS, PRECHARGE comes exactly tRAS clocks after that ACTIVATE.
- R9: For a READ on the pins in cycle p with latency CL, the words on `sd_dq` in cycles p+CL and p+CL+1 are returned on `rsp_data` with `rsp_valid` high in cycles p+CL+1 and p+CL+2.
- R10: A timing configuration value of 0 behaves as 1 clock.
- R11: `req_ready` drops in the cycle after a request is accepted and stays low until that request's READ is issued. Responses come back in the order the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 4 | Read latency in clocks |
| cfg_rcd | input | 4 | Activate-to-read delay in clocks |
| cfg_ras | input | 4 | Minimum activate-to-precharge time in clocks |
| cfg_rp | input | 4 | Precharge-to-activate time in clocks |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_bank | input | 2 | Request bank |
| req_row | input | 13 | Request row |
| req_col | input | 10 | Request column |
| rsp_valid | output | 1 | Returned word valid |
| rsp_data | output | 16 | Returned word |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a10 | output | 1 | Address line 10 |
| sd_a_hi | output | 2 | Address lines 12:11 |
| sd_a_lo | output | 10 | Address lines 9:0 |
| sd_dqm | output | 2 | Byte masks, held low |
| sd_dq | input | 16 | Read data from SDRAM |

## Verification
The embedded assertions check several properties in every cycle: that the programmed minimum spacing holds between activate, read and precharge, that no READ follows another READ directly, that A10 is low on READ, that no READ is issued without an open row, that the ready signal falls after an accept, and that response words arrive in pairs. Other properties need the bench's scenarios and its reference model. These are that hits never re-open the row, that hit reads are exactly two clocks apart, that the row miss and tRAS paths run at exactly the programmed delays, that a zero configuration acts as one clock, and that the right column's data comes back in the exact cycle the latency implies.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } sd_cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(sd_cmd_e c);
    case (c)
      CMD_ACT: return 4'b0011;
      CMD_RD:  return 4'b0101;
      CMD_PRE: return 4'b0010;
      default: return 4'b0111;
    endcase
  endfunction

  localparam int BURST_LEN = 2;

endpackage

// File: rtl/sdrs_dly.sv
// Down-counting delay: done is high once len clocks have passed since start.
module sdrs_dly #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = (len == '0) ? '0 : len - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sdrs_rdcap.sv
// Tracks reads in flight and captures both burst words at the latency tap.
module sdrs_rdcap #(
  parameter int CNT_W = 4,
  parameter int DQ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [CNT_W-1:0] lat,
  input  logic [DQ_W-1:0]  dq,
  output logic             rsp_valid,
  output logic [DQ_W-1:0]  rsp_data
);
  localparam int IW    = CNT_W + 1;
  localparam int DEPTH = 2 ** IW;

  logic [DEPTH-1:0] sh_q;
  logic [IW-1:0]    tap0, tap1;
  logic             cap;
  logic [DQ_W-1:0]  data_q;
  logic             vld_q;

  always_comb begin
    tap0 = (lat == '0) ? IW'(1) : {1'b0, lat};
    tap1 = tap0 + IW'(1);
    cap  = sh_q[tap0] | sh_q[tap1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      sh_q  <= {sh_q[DEPTH-2:0], issue};
      vld_q <= cap;
      if (cap) data_q <= dq;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

  AST_RSP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |=> vld_q); // R9
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdrs_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int DQ_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_cas_lat,
  input  logic [CNT_W-1:0]  cfg_rcd,
  input  logic [CNT_W-1:0]  cfg_ras,
  input  logic [CNT_W-1:0]  cfg_rp,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_a10,
  output logic [1:0]        sd_a_hi,
  output logic [9:0]        sd_a_lo,
  output logic [DQ_W/8-1:0] sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq
);
  localparam int AGE_W = 8;

  // held request and open-row state
  logic             pend_q, pend_d;
  logic [BA_W-1:0]  pba_q, pba_d;
  logic [ROW_W-1:0] prow_q, prow_d;
  logic [COL_W-1:0] pcol_q, pcol_d;
  logic             open_q, open_d;
  logic [BA_W-1:0]  oba_q, oba_d;
  logic [ROW_W-1:0] orow_q, orow_d;

  // registered pin state
  sd_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [12:0]      addr_q, addr_d;

  logic rcd_ok, ras_ok, rp_ok, gap_ok, hit;
  logic [12:0] row_ext;

  sdrs_dly #(.CNT_W(CNT_W)) u_rcd (.clk(clk), .rst_n(rst_n),
    .start(cmd_d == CMD_ACT), .len(cfg_rcd), .done(rcd_ok));
  sdrs_dly #(.CNT_W(CNT_W)) u_ras (.clk(clk), .rst_n(rst_n),
    .start(cmd_d == CMD_ACT), .len(cfg_ras), .done(ras_ok));
  sdrs_dly #(.CNT_W(CNT_W)) u_rp  (.clk(clk), .rst_n(rst_n),
    .start(cmd_d == CMD_PRE), .len(cfg_rp),  .done(rp_ok));
  sdrs_dly #(.CNT_W(CNT_W)) u_gap (.clk(clk), .rst_n(rst_n),
    .start(cmd_d == CMD_RD),  .len(CNT_W'(BURST_LEN)), .done(gap_ok));

  sdrs_rdcap #(.CNT_W(CNT_W), .DQ_W(DQ_W)) u_cap (.clk(clk), .rst_n(rst_n),
    .issue(cmd_d == CMD_RD), .lat(cfg_cas_lat), .dq(sd_dq),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  assign req_ready = !pend_q;
  assign hit       = open_q && (pba_q == oba_q) && (prow_q == orow_q);
  assign row_ext   = 13'(prow_q);

  always_comb begin
    cmd_d  = CMD_NOP;
    pend_d = pend_q;
    pba_d  = pba_q;
    prow_d = prow_q;
    pcol_d = pcol_q;
    open_d = open_q;
    oba_d  = oba_q;
    orow_d = orow_q;
    ba_d   = '0;
    addr_d = '0;

    if (pend_q) begin
      if (hit) begin
        if (rcd_ok && gap_ok) cmd_d = CMD_RD;
      end else if (open_q) begin
        if (ras_ok && gap_ok) cmd_d = CMD_PRE;
      end else if (rp_ok) begin
        cmd_d = CMD_ACT;
      end
    end

    case (cmd_d)
      CMD_ACT: begin
        open_d = 1'b1;
        oba_d  = pba_q;
        orow_d = prow_q;
        ba_d   = pba_q;
        addr_d = row_ext;
      end
      CMD_RD: begin
        pend_d = 1'b0;
        ba_d   = pba_q;
        addr_d = {3'b000, 10'(pcol_q)};
      end
      CMD_PRE: begin
        open_d = 1'b0;
        ba_d   = oba_q;
      end
      default: ;
    endcase

    if (req_valid && req_ready) begin
      pend_d = 1'b1;
      pba_d  = req_bank;
      prow_d = req_row;
      pcol_d = req_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pba_q  <= '0;
      prow_q <= '0;
      pcol_q <= '0;
      open_q <= 1'b0;
      oba_q  <= '0;
      orow_q <= '0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      pba_q  <= pba_d;
      prow_q <= prow_d;
      pcol_q <= pcol_d;
      open_q <= open_d;
      oba_q  <= oba_d;
      orow_q <= orow_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins(cmd_q);
  assign sd_cke  = 1'b1;
  assign sd_dqm  = '0;
  assign sd_ba   = ba_q;
  assign sd_a_hi = addr_q[12:11];
  assign sd_a10  = addr_q[10];
  assign sd_a_lo = addr_q[9:0];

  // ---------------- assertions ----------------
  logic [AGE_W-1:0] age_act_q, age_pre_q;
  logic [CNT_W-1:0] rcd_e, ras_e, rp_e;

  assign rcd_e = (cfg_rcd == '0) ? CNT_W'(1) : cfg_rcd;
  assign ras_e = (cfg_ras == '0) ? CNT_W'(1) : cfg_ras;
  assign rp_e  = (cfg_rp  == '0) ? CNT_W'(1) : cfg_rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_act_q <= '1;
      age_pre_q <= '1;
    end else begin
      if (cmd_q == CMD_ACT)     age_act_q <= AGE_W'(1);
      else if (age_act_q != '1) age_act_q <= age_act_q + AGE_W'(1);
      if (cmd_q == CMD_PRE)     age_pre_q <= AGE_W'(1);
      else if (age_pre_q != '1) age_pre_q <= age_pre_q + AGE_W'(1);
    end
  end

  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (age_act_q >= AGE_W'(rcd_e))); // R4
  AST_RD_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (!sd_a10 && sd_a_hi == 2'b00)); // R5
  AST_RD_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (open_q && sd_ba == oba_q)); // R6
  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |=> (cmd_q != CMD_RD)); // R6
  AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> (age_pre_q >= AGE_W'(rp_e))); // R7
  AST_RAS_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (age_act_q >= AGE_W'(ras_e))); // R8
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
endmodule

// File: tb/tb_sdram_rd_seq.sv
module tb_sdram_rd_seq;
  logic        clk, rst_n;
  logic [3:0]  cfg_cl, cfg_rcd, cfg_ras, cfg_rp;
  logic        req_valid, req_ready;
  logic [1:0]  req_bank;
  logic [12:0] req_row;
  logic [9:0]  req_col;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [1:0]  sd_ba, sd_a_hi, sd_dqm;
  logic [9:0]  sd_a_lo;
  logic [15:0] dq_drv;

  sdram_rd_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(cfg_cl), .cfg_rcd(cfg_rcd), .cfg_ras(cfg_ras), .cfg_rp(cfg_rp),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a10(sd_a10),
    .sd_a_hi(sd_a_hi), .sd_a_lo(sd_a_lo), .sd_dqm(sd_dqm), .sd_dq(dq_drv));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [15:0] word(input logic [1:0] b, input logic [12:0] r,
                                       input logic [9:0] c, input bit i);
    return {b, r[4:0], c[7:0], i};
  endfunction

  // reference model state
  logic [1:0]  q_ba[$];
  logic [12:0] q_row[$];
  logic [9:0]  q_col[$];
  int          dq_cyc[$];
  logic [15:0] dq_val[$];
  int          ex_cyc[$];
  logic [15:0] ex_val[$];
  int          act_log[$], pre_log[$], rd_log[$];
  bit          m_open, pre_after_act, rd_after_act;
  logic [1:0]  m_ba;
  logic [12:0] m_row;
  int          last_act, last_pre, last_rd;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle reference comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] pins;
      pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      chk(sd_cke == 1'b1 && sd_dqm == 2'b00, "R2", "cke/dqm", {sd_cke, sd_dqm}, 3'b100);
      chk(pins inside {4'b0111, 4'b0011, 4'b0101, 4'b0010}, "R3", "command pins", pins, 4'b0111);
      if (pins == 4'b0011) begin  // ACTIVATE
        chk(!m_open, "R7", "activate with row open", m_open, 0);
        chk(q_ba.size() > 0, "R4", "activate without request", q_ba.size(), 1);
        if (q_ba.size() > 0) begin
          chk(sd_ba == q_ba[0], "R4", "act bank", sd_ba, q_ba[0]);
          chk({sd_a_hi, sd_a10, sd_a_lo} == q_row[0], "R4", "act row",
              {sd_a_hi, sd_a10, sd_a_lo}, q_row[0]);
          m_ba = q_ba[0]; m_row = q_row[0];
        end
        if (pre_after_act)
          chk(cyc - last_pre == eff(cfg_rp), "R7", "precharge to activate", cyc - last_pre, eff(cfg_rp));
        m_open = 1; last_act = cyc; pre_after_act = 0; rd_after_act = 0;
        act_log.push_back(cyc);
      end else if (pins == 4'b0010) begin  // PRECHARGE
        chk(m_open, "R7", "precharge with no row", m_open, 1);
        chk(sd_ba == m_ba && !sd_a10, "R5", "precharge bank", sd_ba, m_ba);
        chk(cyc - last_act >= eff(cfg_ras), "R8", "activate to precharge", cyc - last_act, eff(cfg_ras));
        chk(q_ba.size() > 0 && !(q_ba[0] == m_ba && q_row[0] == m_row), "R7",
            "precharge on a hit", 0, 1);
        m_open = 0; last_pre = cyc; pre_after_act = 1;
        pre_log.push_back(cyc);
      end else if (pins == 4'b0101) begin  // READ
        chk(q_ba.size() > 0, "R11", "read without request", q_ba.size(), 1);
        if (q_ba.size() > 0) begin
          chk(m_open && q_ba[0] == m_ba && q_row[0] == m_row, "R6", "read row is open", 0, 1);
          chk(sd_ba == q_ba[0], "R5", "read bank", sd_ba, q_ba[0]);
          chk(sd_a_lo == q_col[0] && !sd_a10 && sd_a_hi == 2'b00, "R5", "read column",
              {sd_a_hi, sd_a10, sd_a_lo}, q_col[0]);
          if (!rd_after_act)
            chk(cyc - last_act == eff(cfg_rcd), "R4", "activate to read", cyc - last_act, eff(cfg_rcd));
          else
            chk(cyc - last_rd >= 2, "R6", "read spacing", cyc - last_rd, 2);
          for (int i = 0; i < 2; i++) begin
            dq_cyc.push_back(cyc + eff(cfg_cl) + i);
            dq_val.push_back(word(q_ba[0], q_row[0], q_col[0], i[0]));
            ex_cyc.push_back(cyc + eff(cfg_cl) + 1 + i);
            ex_val.push_back(word(q_ba[0], q_row[0], q_col[0], i[0]));
          end
          void'(q_ba.pop_front()); void'(q_row.pop_front()); void'(q_col.pop_front());
        end
        rd_after_act = 1; last_rd = cyc;
        rd_log.push_back(cyc);
      end
      // responses
      while (ex_cyc.size() > 0 && ex_cyc[0] < cyc) begin
        chk(0, "R9", "missing response word", 0, ex_val[0]);
        void'(ex_cyc.pop_front()); void'(ex_val.pop_front());
      end
      if (rsp_valid) begin
        if (ex_cyc.size() > 0 && ex_cyc[0] == cyc) begin
          chk(rsp_data == ex_val[0], "R9", "response data", rsp_data, ex_val[0]);
          void'(ex_cyc.pop_front()); void'(ex_val.pop_front());
        end else begin
          chk(0, "R9", "unexpected response cycle", cyc, ex_cyc.size() > 0 ? ex_cyc[0] : -1);
        end
      end
      // SDRAM data model
      if (dq_cyc.size() > 0 && dq_cyc[0] == cyc) begin
        dq_drv = dq_val[0];
        void'(dq_cyc.pop_front()); void'(dq_val.pop_front());
      end else begin
        dq_drv = 16'hA5A5;
      end
    end
  end

  // call at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    q_ba.push_back(b); q_row.push_back(r); q_col.push_back(c);
    req_valid = 1'b0;
    chk(!req_ready, "R11", "ready after accept", req_ready, 0);
  endtask

  task automatic drain();
    while (q_ba.size() > 0 || ex_cyc.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    dq_drv = 16'hA5A5;
    cfg_cl = 4'd2; cfg_rcd = 4'd2; cfg_ras = 4'd4; cfg_rp = 4'd2;
    m_open = 0; pre_after_act = 0; rd_after_act = 0;
    last_act = 0; last_pre = 0; last_rd = 0;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!rsp_valid, "R1", "reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    // same-row stream, default timing
    rd_log.delete();
    send(2'd1, 13'd5, 10'd3);
    send(2'd1, 13'd5, 10'd9);
    send(2'd1, 13'd5, 10'd12);
    send(2'd1, 13'd5, 10'd40);
    drain();
    chk(act_log.size() == 1, "R6", "activations for one row", act_log.size(), 1);
    for (int i = 0; i < 3; i++)
      if (rd_log.size() > i + 1)
        chk(rd_log[i+1] - rd_log[i] == 2, "R6", "hit read gap", rd_log[i+1] - rd_log[i], 2);

    // row and bank misses
    send(2'd1, 13'd6, 10'd0);
    send(2'd2, 13'd6, 10'd1);
    send(2'd2, 13'd6, 10'd2);
    send(2'd2, 13'h1C05, 10'd3);
    drain();
    chk(pre_log.size() == 3, "R7", "precharge count", pre_log.size(), 3);

    // reprogrammed timing with a zero value; miss right after activate
    cfg_cl = 4'd3; cfg_rcd = 4'd0; cfg_ras = 4'd7; cfg_rp = 4'd3;
    send(2'd0, 13'd9, 10'd7);
    send(2'd0, 13'd10, 10'd8);
    drain();
    chk(pre_log[$] - act_log[act_log.size()-2] == 7, "R8", "precharge held for tRAS",
        pre_log[$] - act_log[act_log.size()-2], 7);
    chk(rd_log[$] - act_log[$] == 1, "R10", "zero tRCD acts as one",
        rd_log[$] - act_log[$], 1);

    // mixed stream
    cfg_cl = 4'd1; cfg_rcd = 4'd3; cfg_ras = 4'd5; cfg_rp = 4'd1;
    seed = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      send(seed[17:16] & 2'b01, {11'd0, seed[20:19]}, seed[29:20]);
      repeat (seed[31:30] == 2'b11 ? 2 : 0) @(negedge clk);
    end
    drain();
    chk(q_ba.size() == 0 && ex_cyc.size() == 0, "R11", "all requests answered",
        q_ba.size() + ex_cyc.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule